// File: doc/BRIEF.md
# Interlaced Field Identifier Source

This block drives the field-identifier line that travels with a generated video stream. A small configuration word chooses among three behaviours. In the first, progressive content gets a constant level. In the second, interlaced content gets a level that alternates from frame to frame. In the third, a field identifier arriving from an upstream stream is copied through. A polarity bit decides which electrical level stands for the first field.

Frame boundaries are marked by a one-cycle `frame_start` pulse from the timing logic. In interlaced generation the block keeps an internal field state. The first frame after interlaced generation is entered is always the first field, and every later frame flips it. The output is a single flip-flop, so every change of configuration, strobe or upstream level shows up one clock after the edge that samples it.

Top module: `fieldid_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `fid_out` is 0 after that edge, and the internal field state goes back to "no frame seen yet".
- R2: With cfg bit 0 = 0 and cfg bit 2 = 0 (progressive, generating), `fid_out` equals cfg bit 1 one clock later, and `frame_start` has no effect on it.
- R3: With cfg bit 0 = 1 and cfg bit 2 = 0 (interlaced, generating), the field is field 0 until the first `frame_start`. That first strobe leaves it at field 0, and each later strobe toggles it.
- R4: In interlaced generation, `fid_out` one clock after an edge equals the field number (0 or 1) after that edge XOR cfg bit 1. Bit 1 = 0 gives low for field 0 and high for field 1.
- R5: With cfg bit 2 = 1 (passthrough), `fid_out` equals the value `up_fid` had at the previous clock edge, whatever bits 0 and 1 hold.
- R6: Any cycle outside interlaced generation (bit 0 = 0 or bit 2 = 1) discards the field sequence. After interlaced generation is entered again, the next `frame_start` yields field 0.
- R7: cfg bits above bit 2 are reserved and have no effect on `fid_out`.
- R8: In interlaced generation, cycles without `frame_start` leave the field, and so `fid_out`, unchanged while the configuration is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_i | input | CFG_W | Configuration word: bit 0 interlaced, bit 1 inverted polarity, bit 2 passthrough, upper bits reserved |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| up_fid | input | 1 | Field identifier from the upstream stream |
| fid_out | output | 1 | Registered field identifier |

## Verification
A field state that is wrong in interlaced generation shows up on `fid_out` one clock after the strobe that set it. It keeps showing there until the next strobe, because the output is the field XOR the polarity bit. A sequence that is not discarded on leaving interlaced mode appears one clock after the first strobe back in that mode, as the opposite level from the expected field 0. Passthrough or progressive selection errors are visible on the very next clock, because no state sits between the configuration and the output register.

// File: rtl/fid_pkg.sv
package fid_pkg;
  localparam int CFG_ILACE_BIT = 0;
  localparam int CFG_POL_BIT   = 1;
  localparam int CFG_PASS_BIT  = 2;
  localparam int CFG_USED_W    = 3;

  typedef enum logic [1:0] {
    SRC_FIXED = 2'd0,
    SRC_FIELD = 2'd1,
    SRC_UP    = 2'd2
  } fid_src_e;

  typedef struct packed {
    fid_src_e src;
    logic     pol;
  } fid_sel_t;
endpackage

// File: rtl/fid_cfg_decode.sv
module fid_cfg_decode
  import fid_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic [CFG_W-1:0] cfg_i,
  output fid_sel_t         sel_o
);
  generate
    if (CFG_W > CFG_USED_W) begin : g_resv
      logic unused_resv;
      assign unused_resv = ^cfg_i[CFG_W-1:CFG_USED_W];
    end
  endgenerate

  always_comb begin
    sel_o.pol = cfg_i[CFG_POL_BIT];
    if (cfg_i[CFG_PASS_BIT])
      sel_o.src = SRC_UP;
    else if (cfg_i[CFG_ILACE_BIT])
      sel_o.src = SRC_FIELD;
    else
      sel_o.src = SRC_FIXED;
  end
endmodule

// File: rtl/fid_field_tracker.sv
module fid_field_tracker (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic frame_start,
  output logic field_d,
  output logic field_q,
  output logic seen_q
);
  logic seen_d;

  always_comb begin
    field_d = field_q;
    seen_d  = seen_q;
    if (!run) begin
      field_d = 1'b0;
      seen_d  = 1'b0;
    end else if (frame_start) begin
      seen_d  = 1'b1;
      field_d = seen_q ? ~field_q : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      field_q <= field_d;
      seen_q  <= seen_d;
    end
  end

  // R3: first strobe gives field 0, later strobes toggle
  p_first_field_r3: assert property (@(posedge clk) disable iff (rst)
    (run && frame_start && !seen_q) |=> (!field_q && seen_q));
  p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (run && frame_start && seen_q) |=> (field_q != $past(field_q)));
  // R8: no strobe, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !frame_start) |=> $stable(field_q));
  // R6: leaving interlaced generation forgets the sequence
  p_forget_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!field_q && !seen_q));
endmodule

// File: rtl/fid_out_stage.sv
module fid_out_stage
  import fid_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  fid_sel_t sel,
  input  logic     field_d,
  input  logic     up_fid,
  output logic     fid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fid_q <= 1'b0;
    end else begin
      case (sel.src)
        SRC_UP:    fid_q <= up_fid;
        SRC_FIELD: fid_q <= field_d ^ sel.pol;
        default:   fid_q <= sel.pol;
      endcase
    end
  end

  // R1: reset drives the output low
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (fid_q == 1'b0));
  // R2: progressive level follows polarity
  p_prog_level_r2: assert property (@(posedge clk) disable iff (rst)
    (sel.src == SRC_FIXED) |=> (fid_q == $past(sel.pol)));
  // R5: passthrough copies upstream with one clock of delay
  p_pass_copy_r5: assert property (@(posedge clk) disable iff (rst)
    (sel.src == SRC_UP) |=> (fid_q == $past(up_fid)));
endmodule

// File: rtl/fieldid_gen.sv
module fieldid_gen
  import fid_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             frame_start,
  input  logic             up_fid,
  output logic             fid_out
);
  fid_sel_t sel;
  logic     run_ilace;
  logic     field_d;
  logic     field_q;
  logic     seen_q;

  fid_cfg_decode #(.CFG_W(CFG_W)) u_dec (
    .cfg_i (cfg_i),
    .sel_o (sel)
  );

  assign run_ilace = (sel.src == SRC_FIELD);

  fid_field_tracker u_trk (
    .clk         (clk),
    .rst         (rst),
    .run         (run_ilace),
    .frame_start (frame_start),
    .field_d     (field_d),
    .field_q     (field_q),
    .seen_q      (seen_q)
  );

  fid_out_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .field_d (field_d),
    .up_fid  (up_fid),
    .fid_q   (fid_out)
  );

  // R4: output in interlaced generation is field XOR polarity
  p_field_polarity_r4: assert property (@(posedge clk) disable iff (rst)
    run_ilace |=> (fid_out == (field_q ^ $past(sel.pol))));
  // R6: no field history survives while outside interlaced generation
  p_no_history_r6: assert property (@(posedge clk) disable iff (rst)
    (!run_ilace && !$past(run_ilace)) |-> !seen_q);
endmodule

// File: tb/fieldid_gen_test.sv
module fieldid_gen_test;
  localparam int CFG_W = 32;
  localparam int NV    = 23;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CFG_W-1:0] cfg_i = '0;
  logic             frame_start = 1'b0;
  logic             up_fid = 1'b0;
  logic             fid_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fieldid_gen #(.CFG_W(CFG_W)) uut (
    .clk         (clk),
    .rst         (rst),
    .cfg_i       (cfg_i),
    .frame_start (frame_start),
    .up_fid      (up_fid),
    .fid_out     (fid_out)
  );

  // vector: {cfg4 (b3 reserved fill, b2 pass, b1 pol, b0 interlaced), fs, up, exp, req}
  typedef struct packed {
    logic [3:0] cfg;
    logic       fs;
    logic       up;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{4'd0,  1'b0, 1'b0, 1'b0, 4'd2},
    '{4'd0,  1'b1, 1'b1, 1'b0, 4'd2},
    '{4'd2,  1'b0, 1'b0, 1'b1, 4'd2},
    '{4'd2,  1'b1, 1'b0, 1'b1, 4'd2},
    '{4'd1,  1'b0, 1'b0, 1'b0, 4'd3},
    '{4'd1,  1'b1, 1'b0, 1'b0, 4'd3},
    '{4'd1,  1'b0, 1'b0, 1'b0, 4'd8},
    '{4'd1,  1'b1, 1'b0, 1'b1, 4'd3},
    '{4'd1,  1'b0, 1'b1, 1'b1, 4'd8},
    '{4'd1,  1'b1, 1'b0, 1'b0, 4'd3},
    '{4'd3,  1'b0, 1'b0, 1'b1, 4'd4},
    '{4'd3,  1'b1, 1'b0, 1'b0, 4'd4},
    '{4'd4,  1'b0, 1'b1, 1'b1, 4'd5},
    '{4'd4,  1'b0, 1'b0, 1'b0, 4'd5},
    '{4'd5,  1'b1, 1'b1, 1'b1, 4'd5},
    '{4'd7,  1'b0, 1'b0, 1'b0, 4'd5},
    '{4'd1,  1'b1, 1'b0, 1'b0, 4'd6},
    '{4'd1,  1'b1, 1'b0, 1'b1, 4'd6},
    '{4'd0,  1'b0, 1'b0, 1'b0, 4'd6},
    '{4'd1,  1'b1, 1'b0, 1'b0, 4'd6},
    '{4'd9,  1'b1, 1'b0, 1'b1, 4'd7},
    '{4'd11, 1'b0, 1'b0, 1'b0, 4'd7},
    '{4'd12, 1'b0, 1'b1, 1'b1, 4'd7}
  };

  function automatic logic [CFG_W-1:0] mk_cfg(input logic [3:0] c);
    logic [CFG_W-1:0] w;
    w = {{(CFG_W-3){c[3]}}, c[2:0]};
    return w;
  endfunction

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (fid_out !== exp) begin
      n_fail++;
      $display("FAIL %s: fid_out=%0b expected=%0b at %0t", req, fid_out, exp, $time);
    end
  endtask

  // drive at falling edge, sample 1 ns after the rising edge
  task automatic step(input logic r, input logic [3:0] c, input logic fs, input logic up);
    @(negedge clk);
    rst = r; cfg_i = mk_cfg(c); frame_start = fs; up_fid = up;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: expired, expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(1, 4'd0, 0, 0);
    step(1, 4'd2, 1, 1);
    check(1'b0, "R1 reset level");

    foreach (VEC[i]) begin
      step(0, VEC[i].cfg, VEC[i].fs, VEC[i].up);
      check(VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
    end

    // R1: reset in the middle of an interlaced run
    step(0, 4'd1, 1, 0);
    step(0, 4'd1, 1, 0);
    check(1'b1, "R3 field 1 before reset");
    step(1, 4'd1, 0, 0);
    check(1'b0, "R1 reset mid-run");
    step(0, 4'd1, 1, 0);
    check(1'b0, "R1 first strobe after reset is field 0");
    step(0, 4'd1, 1, 0);
    check(1'b1, "R3 second strobe after reset");

    // R8: long idle stretch in interlaced mode with noisy upstream
    for (int k = 0; k < 6; k++) begin
      step(0, 4'd1, 0, k[0]);
      check(1'b1, "R8 hold without strobe");
    end

    // R5: passthrough tracks an alternating upstream with one clock lag
    for (int k = 0; k < 6; k++) begin
      step(0, 4'd6, k[1], k[0]);
      check(k[0], "R5 alternating upstream");
    end

    // R7: reserved bits with inverted polarity in progressive
    step(0, 4'd10, 1, 0);
    check(1'b1, "R7 reserved fill, progressive inverted");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule